// File: doc/BRIEF.md
# Stacked DMA Interrupt Status Register

This block holds the interrupt status of a DMA engine in one 8-bit register that software can only read. Single-cycle event pulses from the engine set the status bits. Examples are a parity error seen as bus master, a bus fault, an abort, a single-step stop, a script-requested interrupt and an illegal instruction. A read returns the register and clears exactly the bits that read returned.

If an event arrives while its bit is still set, or during the read cycle itself, it is not lost. It waits in a second, hidden stage and moves into the visible register on the cycle after the next read. Software that reads until it gets zero therefore sees every event.

The top bit is not an interrupt. It shows the live FIFO-empty condition, and a read does not clear it. A per-source mask register selects which visible bits drive the registered interrupt-pending output. A separate enable input gates capture of parity errors completely.

Top module: `dma_intr_status`

## Requirements
- R1: After reset the read data is 8'h80 when FIFO-empty is high, the mask reads 8'h00 and `irq_o` is 0. Bit 1 is reserved and always reads 0.
- R2: Bit 7 of `rd_data` always equals `fifo_empty_i`. A read does not clear it, and it never causes `irq_o` to go high.
- R3: An event pulse sets its bit on the next clock edge. The bits are: abort on bit 4, single-step on bit 3, script interrupt on bit 2, and illegal instruction on bit 0.
- R4: While `rd_en` is high, `rd_data` shows the current bits. After that clock edge, bits 6..0 are all zero. A read when no bits are set changes nothing.
- R5: An event whose bit is already visible is held. It appears in the visible register one edge after the edge of the next read.
- R6: An event that arrives in the same cycle as a read is not lost. It appears one edge after the read edge.
- R7: Bit 6 sets only when all of these hold: `par_chk_en_i` is high, `is_master_i` is high, and either `data_par_err_i` or `tgt_par_err_i` is high.
- R8: Bit 5 sets only when `is_master_i` is high and either `bad_addr_i` or `tgt_abort_i` is high.
- R9: A write through `mask_we` stores `mask_wdata`. Mask bits 7 and 1 are ignored and read 0.
- R10: `irq_o` is the registered OR of the visible bits 6..0 ANDed with the mask. It goes high one edge after a masked-in bit becomes visible. It goes low one edge after a read empties the register, unless held events reload it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_en | input | 1 | Register read strobe; clears the bits returned |
| rd_data | output | 8 | Status register contents |
| fifo_empty_i | input | 1 | Live FIFO-empty condition |
| par_chk_en_i | input | 1 | Enables parity-error capture |
| is_master_i | input | 1 | Engine currently owns the bus |
| data_par_err_i | input | 1 | Data parity error detected in a data phase |
| tgt_par_err_i | input | 1 | Target reported a parity error |
| bad_addr_i | input | 1 | Cycle ended with a bad address |
| tgt_abort_i | input | 1 | Cycle ended with a target abort |
| abort_evt_i | input | 1 | Abort event pulse |
| sstep_evt_i | input | 1 | Single-step event pulse |
| script_int_evt_i | input | 1 | Script interrupt event pulse |
| bad_op_evt_i | input | 1 | Illegal instruction event pulse |
| mask_we | input | 1 | Mask register write enable |
| mask_wdata | input | 8 | Mask write data |
| mask_q | output | 8 | Mask register contents |
| irq_o | output | 1 | DMA interrupt pending |

## Verification
The tests drive several input patterns:
- A single event into an empty register checks basic set-and-clear.
- A repeated event on a bit that is already set, and an event in the read cycle itself, separate correct stacking from lost or duplicated events.
- The parity and bus-fault sources are driven with each qualifying input missing in turn, which shows that every gate term matters.
- Mask patterns that pass and block one source, together with the interrupt timing around a read, separate the registered summary from a live or unmasked one.

// File: rtl/dma_intr_status_pkg.sv
// Shared constants for the stacked DMA interrupt status register.
// Assumes an 8-bit register with bit 7 as live status and bits 6..0 as events.
package dma_intr_status_pkg;
    localparam int REG_W      = 8;
    localparam int EVT_W      = REG_W - 1;
    localparam int BIT_PAR    = 6;
    localparam int BIT_BFAULT = 5;
    localparam int BIT_ABORT  = 4;
    localparam int BIT_SSTEP  = 3;
    localparam int BIT_SCRIPT = 2;
    localparam int BIT_RSVD   = 1;
    localparam int BIT_BADOP  = 0;
    localparam logic [EVT_W-1:0] EVT_VALID = ~(EVT_W'(1) << BIT_RSVD);
endpackage

// File: rtl/dma_intr_event_qual.sv
// Turns raw engine conditions into one event vector.
// Assumes all inputs are synchronous to clk; the reserved bit is held at zero.
module dma_intr_event_qual
    import dma_intr_status_pkg::*;
(
    input  logic             par_chk_en_i,
    input  logic             is_master_i,
    input  logic             data_par_err_i,
    input  logic             tgt_par_err_i,
    input  logic             bad_addr_i,
    input  logic             tgt_abort_i,
    input  logic             abort_evt_i,
    input  logic             sstep_evt_i,
    input  logic             script_int_evt_i,
    input  logic             bad_op_evt_i,
    output logic [EVT_W-1:0] evt_o
);
    // Gate bus-master sources and place every source at its bit.
    always_comb begin
        evt_o             = '0;
        evt_o[BIT_PAR]    = par_chk_en_i & is_master_i & (data_par_err_i | tgt_par_err_i);
        evt_o[BIT_BFAULT] = is_master_i & (bad_addr_i | tgt_abort_i);
        evt_o[BIT_ABORT]  = abort_evt_i;
        evt_o[BIT_SSTEP]  = sstep_evt_i;
        evt_o[BIT_SCRIPT] = script_int_evt_i;
        evt_o[BIT_BADOP]  = bad_op_evt_i;
    end
endmodule

// File: rtl/dma_intr_stack.sv
// Two-stage event store: a visible stage that software reads and a hidden
// pending stage. A read clears the visible stage; the next cycle promotes the
// pending stage. Assumes rd_en is a one-cycle strobe per register read.
module dma_intr_stack
    import dma_intr_status_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [EVT_W-1:0] evt_i,
    output logic [EVT_W-1:0] vis_o
);
    logic promote_q;

    // Remember that the previous cycle was a read, so pending bits move up now.
    always_ff @(posedge clk) begin
        if (!rst_n) promote_q <= 1'b0;
        else        promote_q <= rd_en;
    end

    for (genvar i = 0; i < EVT_W; i++) begin : g_bit
        if (EVT_VALID[i]) begin : g_cell
            logic vis_q, pend_q, base;
            assign base = vis_q | (promote_q & pend_q);
            // Per-bit update: a read clears the visible stage and feeds the
            // pending stage; otherwise a repeat event stacks into pending.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vis_q  <= 1'b0;
                    pend_q <= 1'b0;
                end else if (rd_en) begin
                    vis_q  <= 1'b0;
                    pend_q <= pend_q | evt_i[i];
                end else begin
                    vis_q  <= base | evt_i[i];
                    pend_q <= (pend_q & ~promote_q) | (evt_i[i] & base);
                end
            end
            assign vis_o[i] = vis_q;
        end else begin : g_rsvd
            assign vis_o[i] = 1'b0;
        end
    end
endmodule

// File: rtl/dma_intr_irq_sum.sv
// Holds the per-source mask and forms the registered interrupt summary.
// Assumes the mask write port is driven by the register decode elsewhere.
module dma_intr_irq_sum
    import dma_intr_status_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mask_we,
    input  logic [REG_W-1:0] mask_wdata,
    input  logic [EVT_W-1:0] vis_i,
    output logic [REG_W-1:0] mask_q,
    output logic             irq_o
);
    logic [EVT_W-1:0] mask_r;

    // Mask storage; only interrupting, non-reserved bits are kept.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_r <= '0;
        else if (mask_we) mask_r <= mask_wdata[EVT_W-1:0] & EVT_VALID;
    end

    // Summary flag, one cycle behind the visible bits.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= |(vis_i & mask_r);
    end

    assign mask_q = {1'b0, mask_r};
endmodule

// File: rtl/dma_intr_status.sv
// Top of the stacked DMA interrupt status register: qualifies events, stacks
// them in two stages and drives the read data, mask and summary interrupt.
// Assumes synchronous single-cycle read strobes.
module dma_intr_status
    import dma_intr_status_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    output logic [REG_W-1:0] rd_data,
    input  logic             fifo_empty_i,
    input  logic             par_chk_en_i,
    input  logic             is_master_i,
    input  logic             data_par_err_i,
    input  logic             tgt_par_err_i,
    input  logic             bad_addr_i,
    input  logic             tgt_abort_i,
    input  logic             abort_evt_i,
    input  logic             sstep_evt_i,
    input  logic             script_int_evt_i,
    input  logic             bad_op_evt_i,
    input  logic             mask_we,
    input  logic [REG_W-1:0] mask_wdata,
    output logic [REG_W-1:0] mask_q,
    output logic             irq_o
);
    logic [EVT_W-1:0] evt;
    logic [EVT_W-1:0] vis;

    dma_intr_event_qual u_qual (
        .par_chk_en_i     (par_chk_en_i),
        .is_master_i      (is_master_i),
        .data_par_err_i   (data_par_err_i),
        .tgt_par_err_i    (tgt_par_err_i),
        .bad_addr_i       (bad_addr_i),
        .tgt_abort_i      (tgt_abort_i),
        .abort_evt_i      (abort_evt_i),
        .sstep_evt_i      (sstep_evt_i),
        .script_int_evt_i (script_int_evt_i),
        .bad_op_evt_i     (bad_op_evt_i),
        .evt_o            (evt)
    );

    dma_intr_stack u_stack (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_en (rd_en),
        .evt_i (evt),
        .vis_o (vis)
    );

    dma_intr_irq_sum u_sum (
        .clk        (clk),
        .rst_n      (rst_n),
        .mask_we    (mask_we),
        .mask_wdata (mask_wdata),
        .vis_i      (vis),
        .mask_q     (mask_q),
        .irq_o      (irq_o)
    );

    // Read data: live FIFO-empty on top of the visible event bits.
    assign rd_data = {fifo_empty_i, vis};
endmodule

// File: rtl/dma_intr_status_chk.sv
// Property checker bound to the status register top.
module dma_intr_status_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_en,
    input logic [7:0] rd_data,
    input logic       fifo_empty_i,
    input logic [7:0] mask_q,
    input logic       irq_o
);
    // R4
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> (rd_data[6:0] == 7'd0));

    // R1
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[1] == 1'b0);

    // R2
    live_fifo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[7] == fifo_empty_i);

    // R9
    mask_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q[7] == 1'b0) && (mask_q[1] == 1'b0));

    // R10
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == $past(|(rd_data[6:0] & mask_q[6:0])));
endmodule

bind dma_intr_status dma_intr_status_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_en        (rd_en),
    .rd_data      (rd_data),
    .fifo_empty_i (fifo_empty_i),
    .mask_q       (mask_q),
    .irq_o        (irq_o)
);

// File: tb/dma_intr_status_test.sv
module dma_intr_status_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       fifo_empty_i = 1'b1;
    logic       par_chk_en_i = 1'b0;
    logic       is_master_i = 1'b0;
    logic       data_par_err_i = 1'b0;
    logic       tgt_par_err_i = 1'b0;
    logic       bad_addr_i = 1'b0;
    logic       tgt_abort_i = 1'b0;
    logic       abort_evt_i = 1'b0;
    logic       sstep_evt_i = 1'b0;
    logic       script_int_evt_i = 1'b0;
    logic       bad_op_evt_i = 1'b0;
    logic       mask_we = 1'b0;
    logic [7:0] mask_wdata = 8'h00;
    logic [7:0] mask_q;
    logic       irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dma_intr_status uut (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_data(rd_data),
        .fifo_empty_i(fifo_empty_i), .par_chk_en_i(par_chk_en_i),
        .is_master_i(is_master_i), .data_par_err_i(data_par_err_i),
        .tgt_par_err_i(tgt_par_err_i), .bad_addr_i(bad_addr_i),
        .tgt_abort_i(tgt_abort_i), .abort_evt_i(abort_evt_i),
        .sstep_evt_i(sstep_evt_i), .script_int_evt_i(script_int_evt_i),
        .bad_op_evt_i(bad_op_evt_i), .mask_we(mask_we),
        .mask_wdata(mask_wdata), .mask_q(mask_q), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic read_once();
        rd_en = 1'b1;
        step();
        rd_en = 1'b0;
    endtask

    task automatic drain();
        for (int k = 0; k < 3; k++) begin
            read_once();
            step();
        end
        step();
    endtask

    task automatic write_mask(input logic [7:0] v);
        mask_we = 1'b1;
        mask_wdata = v;
        step();
        mask_we = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 reset data", rd_data, 8'h80);
        check("R1 reset mask", mask_q, 8'h00);
        check("R1 reset irq", {7'd0, irq_o}, 8'h00);
    endtask

    task automatic t_live_bit();
        write_mask(8'hFF);
        check("R9 mask ignored bits", mask_q, 8'h7D);
        fifo_empty_i = 1'b0;
        #1 check("R2 live low", rd_data, 8'h00);
        fifo_empty_i = 1'b1;
        read_once();
        check("R2 not cleared by read", rd_data, 8'h80);
        step();
        check("R2 no irq", {7'd0, irq_o}, 8'h00);
        check("R4 empty read no effect", rd_data, 8'h80);
    endtask

    task automatic t_sources();
        abort_evt_i = 1'b1; sstep_evt_i = 1'b1; script_int_evt_i = 1'b1; bad_op_evt_i = 1'b1;
        step();
        abort_evt_i = 1'b0; sstep_evt_i = 1'b0; script_int_evt_i = 1'b0; bad_op_evt_i = 1'b0;
        check("R3 event bits", rd_data, 8'h9D);
        check("R1 reserved bit", {7'd0, rd_data[1]}, 8'h00);
        rd_en = 1'b1;
        #1 check("R4 read returns bits", rd_data, 8'h9D);
        step();
        rd_en = 1'b0;
        check("R4 cleared after read", rd_data, 8'h80);
        drain();
    endtask

    task automatic t_stack();
        abort_evt_i = 1'b1; step(); step(); abort_evt_i = 1'b0;
        check("R5 first visible", rd_data, 8'h90);
        read_once();
        check("R5 cleared by read", rd_data, 8'h80);
        step();
        check("R5 stacked event appears", rd_data, 8'h90);
        read_once();
        step();
        check("R5 single stacked copy", rd_data, 8'h80);
    endtask

    task automatic t_read_collision();
        script_int_evt_i = 1'b1; step(); script_int_evt_i = 1'b0;
        rd_en = 1'b1; sstep_evt_i = 1'b1;
        #1 check("R6 read value", rd_data, 8'h84);
        step();
        rd_en = 1'b0; sstep_evt_i = 1'b0;
        check("R6 hidden during promote", rd_data, 8'h80);
        step();
        check("R6 event not lost", rd_data, 8'h88);
        drain();
    endtask

    task automatic t_parity();
        is_master_i = 1'b1; par_chk_en_i = 1'b0; data_par_err_i = 1'b1;
        step(); data_par_err_i = 1'b0;
        check("R7 disabled", rd_data, 8'h80);
        is_master_i = 1'b0; par_chk_en_i = 1'b1; tgt_par_err_i = 1'b1;
        step(); tgt_par_err_i = 1'b0;
        check("R7 not master", rd_data, 8'h80);
        is_master_i = 1'b1; tgt_par_err_i = 1'b1;
        step(); tgt_par_err_i = 1'b0;
        check("R7 target parity", rd_data, 8'hC0);
        drain();
        data_par_err_i = 1'b1;
        step(); data_par_err_i = 1'b0;
        check("R7 data parity", rd_data, 8'hC0);
        drain();
        par_chk_en_i = 1'b0;
    endtask

    task automatic t_bus_fault();
        is_master_i = 1'b0; bad_addr_i = 1'b1; tgt_abort_i = 1'b1;
        step(); bad_addr_i = 1'b0; tgt_abort_i = 1'b0;
        check("R8 not master", rd_data, 8'h80);
        is_master_i = 1'b1; tgt_abort_i = 1'b1;
        step(); tgt_abort_i = 1'b0;
        check("R8 target abort", rd_data, 8'hA0);
        drain();
        bad_addr_i = 1'b1;
        step(); bad_addr_i = 1'b0; is_master_i = 1'b0;
        check("R8 bad address", rd_data, 8'hA0);
        drain();
    endtask

    task automatic t_irq();
        write_mask(8'h04);
        check("R9 mask write", mask_q, 8'h04);
        abort_evt_i = 1'b1; step(); abort_evt_i = 1'b0;
        step();
        check("R10 masked out source", {7'd0, irq_o}, 8'h00);
        drain();
        script_int_evt_i = 1'b1; step(); script_int_evt_i = 1'b0;
        check("R10 one cycle lag", {7'd0, irq_o}, 8'h00);
        step();
        check("R10 raised", {7'd0, irq_o}, 8'h01);
        read_once();
        check("R10 still high at read edge", {7'd0, irq_o}, 8'h01);
        step();
        check("R10 cleared after read", {7'd0, irq_o}, 8'h00);
        script_int_evt_i = 1'b1; step(); step(); script_int_evt_i = 1'b0;
        read_once();
        step();
        step();
        check("R10 reloaded by stacked event", {7'd0, irq_o}, 8'h01);
        drain();
        check("R10 low when empty", {7'd0, irq_o}, 8'h00);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        step();
        t_reset();
        t_live_bit();
        t_sources();
        t_stack();
        t_read_collision();
        t_parity();
        t_bus_fault();
        t_irq();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule